// File: doc/BRIEF.md
# Dual-Mode Pixel Output Formatter

This block sits between a video link decoder and a flat-panel interface. It accepts decoded 24-bit RGB pixels together with a data-enable flag, horizontal and vertical sync and three general control bits, at one pixel per pixel period. It presents them on two 24-bit buses, an even bus and an odd bus, either one pixel per output clock or two pixels per output clock. Alongside the data it produces an output clock qualifier, `out_clk`, whose capture edge can be chosen. It can also be gated by data-enable for panels that need no clock during blanking. In two-pixel mode the even bus can be time-staggered against the odd bus.

Everything runs on one fast clock `clk`. A pixel is offered on a cycle where `pix_stb` is high, and strobes arrive every `TICKS` cycles (`TICKS` even, at least 2). The output clock is a level signal in the same domain. Its period is `TICKS` cycles in one-pixel mode and `2*TICKS` cycles in two-pixel mode. The four `cfg_*` inputs are static straps and change only while `rst` is high.

Top module: `pix_pair_fmt`

## Requirements
- R1: With `cfg_dual` low, every strobed pixel appears on `out_even` at the clock edge that samples the strobe, and `out_odd` is held at zero.
- R2: With `cfg_dual` high, an even pixel and the odd pixel that follows it appear together at the edge that samples the odd pixel's strobe. The pairing phase restarts at each rise of data-enable. If data-enable changes between the two pixels of a pair, the first pixel is emitted alone with `out_odd` zero, and the new pixel starts the next pair.
- R3: After each output update the output clock spends `TICKS/2` cycles (one-pixel mode) or `TICKS` cycles (two-pixel mode) in its first half-phase, then switches to its second half-phase. This gives an output period of `TICKS` or `2*TICKS` cycles.
- R4: With `cfg_gate` high, `out_clk` is held low whenever `out_de` is low. With `cfg_gate` low, the clock runs regardless of `out_de`.
- R5: With `cfg_rise` high, `out_clk` is low in the first half-phase after an update and high in the second, so data is captured on the rising edge. With `cfg_rise` low the levels are inverted and capture is on the falling edge.
- R6: With `cfg_dual` high and `cfg_stag_n` low, `out_even` changes `TICKS/2` cycles (a quarter output period) after `out_odd` and the control outputs. In every other strap combination `out_even` changes together with them.
- R7: On both buses, red occupies bits 23:16, green bits 15:8 and blue bits 7:0.
- R8: Any slot whose pixel was strobed with data-enable low is driven as zero on its bus.
- R9: `out_de`, `out_hs`, `out_vs` and `out_ctl` change at the same edge as the pixel buses. In two-pixel mode they carry the values strobed with the even (first) pixel of the pair.
- R10: While `rst` is high, both pixel buses and all control outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, `TICKS` cycles per pixel |
| rst | input | 1 | Synchronous active-high reset |
| pix_stb | input | 1 | One-cycle strobe marking a valid input pixel |
| pix_de | input | 1 | Input data-enable (high = active video) |
| pix_hs | input | 1 | Input horizontal sync |
| pix_vs | input | 1 | Input vertical sync |
| pix_ctl | input | 3 | Input general control bits |
| pix_rgb | input | 24 | Input pixel {red, green, blue} |
| cfg_dual | input | 1 | Strap: 1 = two pixels per output clock |
| cfg_gate | input | 1 | Strap: 1 = output clock held low while `out_de` low |
| cfg_rise | input | 1 | Strap: 1 = capture on rising edge, 0 = falling edge |
| cfg_stag_n | input | 1 | Strap, active low: stagger even bus in two-pixel mode |
| out_even | output | 24 | Even pixel bus (all pixels in one-pixel mode) |
| out_odd | output | 24 | Odd pixel bus (zero in one-pixel mode) |
| out_de | output | 1 | Output data-enable |
| out_hs | output | 1 | Output horizontal sync |
| out_vs | output | 1 | Output vertical sync |
| out_ctl | output | 3 | Output general control bits |
| out_clk | output | 1 | Output clock qualifier |

## Verification
The bench builds the block with its default `TICKS` of 4. With this value a two-pixel output period is eight cycles and the stagger delay is two cycles, so every phase of both clock shapes can be checked cycle by cycle. The bench sweeps all sixteen strap combinations. Each combination is driven with lines of odd and even lengths, separated by blanking runs of odd and even lengths, so that data-enable rises and falls on both pairing phases. The same stimulus therefore reaches the split-pair flushes, the zeroed odd slot and the gated clock in blanking.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

    localparam int CW    = 8;   // bits per colour component
    localparam int CTL_W = 3;   // general control bits

    // red is most significant, blue least significant
    typedef struct packed {
        logic [CW-1:0] red;
        logic [CW-1:0] green;
        logic [CW-1:0] blue;
    } pixel_t;

    localparam int PIX_W = $bits(pixel_t);

    typedef struct packed {
        logic             de;
        logic             hs;
        logic             vs;
        logic [CTL_W-1:0] ctl;
    } sync_t;

    // pixel content only has meaning with data-enable high
    function automatic pixel_t blank_mask(pixel_t p, logic de);
        return de ? p : '0;
    endfunction

endpackage

// File: rtl/ppf_pairer.sv
module ppf_pairer
    import ppf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_dual,
    input  logic   stb,
    input  pixel_t cur_pix,
    input  sync_t  cur_sync,
    output logic   load,
    output pixel_t even_q,
    output pixel_t odd_q,
    output sync_t  sync_q
);

    logic   slot;       // a first pixel is being held
    pixel_t hold_pix;
    sync_t  hold_sync;
    logic   take_hold;
    pixel_t n_even;
    pixel_t n_odd;
    sync_t  n_sync;

    always_comb begin
        load      = 1'b0;
        take_hold = 1'b0;
        n_even    = blank_mask(cur_pix, cur_sync.de);
        n_odd     = '0;
        n_sync    = cur_sync;
        if (stb) begin
            if (!cfg_dual) begin
                load = 1'b1;
            end else if (!slot) begin
                take_hold = 1'b1;
            end else begin
                load   = 1'b1;
                n_even = blank_mask(hold_pix, hold_sync.de);
                n_sync = hold_sync;
                if (cur_sync.de == hold_sync.de) begin
                    n_odd = blank_mask(cur_pix, cur_sync.de);
                end else begin
                    // enable changed mid-pair: flush alone, restart pairing
                    take_hold = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= 1'b0;
            hold_pix  <= '0;
            hold_sync <= '0;
            even_q    <= '0;
            odd_q     <= '0;
            sync_q    <= '0;
        end else begin
            if (load) begin
                even_q <= n_even;
                odd_q  <= n_odd;
                sync_q <= n_sync;
            end
            if (take_hold) begin
                hold_pix  <= cur_pix;
                hold_sync <= cur_sync;
            end
            if (stb && cfg_dual) begin
                slot <= take_hold;
            end
        end
    end

endmodule

// File: rtl/ppf_clkgen.sv
module ppf_clkgen #(
    parameter int TICKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic cfg_dual,
    input  logic cfg_rise,
    input  logic cfg_gate,
    input  logic de_q,
    output logic oclk
);

    localparam int PH_MAX = 2 * TICKS - 1;
    localparam int PH_W   = $clog2(2 * TICKS);

    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] half;
    logic            second_half;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (load) begin
            ph <= '0;
        end else if (ph != PH_W'(PH_MAX)) begin
            ph <= ph + 1'b1;
        end
    end

    assign half        = cfg_dual ? PH_W'(TICKS) : PH_W'(TICKS / 2);
    assign second_half = (ph >= half);
    assign oclk        = (cfg_gate && !de_q) ? 1'b0
                       : (cfg_rise ? second_half : !second_half);

endmodule

// File: rtl/ppf_stagger.sv
module ppf_stagger #(
    parameter int W     = 24,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] sh [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) sh[i] <= '0;
        end else begin
            sh[0] <= d;
            for (int i = 1; i < DEPTH; i++) sh[i] <= sh[i-1];
        end
    end

    assign q = sh[DEPTH-1];

endmodule

// File: rtl/pix_pair_fmt.sv
module pix_pair_fmt #(
    parameter int TICKS = 4   // fast cycles per pixel, even and >= 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        pix_stb,
    input  logic                        pix_de,
    input  logic                        pix_hs,
    input  logic                        pix_vs,
    input  logic [ppf_pkg::CTL_W-1:0]   pix_ctl,
    input  logic [ppf_pkg::PIX_W-1:0]   pix_rgb,
    input  logic                        cfg_dual,
    input  logic                        cfg_gate,
    input  logic                        cfg_rise,
    input  logic                        cfg_stag_n,
    output logic [ppf_pkg::PIX_W-1:0]   out_even,
    output logic [ppf_pkg::PIX_W-1:0]   out_odd,
    output logic                        out_de,
    output logic                        out_hs,
    output logic                        out_vs,
    output logic [ppf_pkg::CTL_W-1:0]   out_ctl,
    output logic                        out_clk
);
    import ppf_pkg::*;

    localparam int STAG_D = TICKS / 2;   // quarter of a two-pixel period

    pixel_t cur_pix;
    sync_t  cur_sync;
    logic   load;
    pixel_t even_q;
    pixel_t odd_q;
    sync_t  sync_q;
    logic [PIX_W-1:0] even_late;
    logic   stag_on;

    assign cur_pix  = pixel_t'(pix_rgb);
    assign cur_sync = {pix_de, pix_hs, pix_vs, pix_ctl};

    ppf_pairer u_pair (
        .clk      (clk),
        .rst      (rst),
        .cfg_dual (cfg_dual),
        .stb      (pix_stb),
        .cur_pix  (cur_pix),
        .cur_sync (cur_sync),
        .load     (load),
        .even_q   (even_q),
        .odd_q    (odd_q),
        .sync_q   (sync_q)
    );

    ppf_clkgen #(.TICKS(TICKS)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .cfg_dual (cfg_dual),
        .cfg_rise (cfg_rise),
        .cfg_gate (cfg_gate),
        .de_q     (sync_q.de),
        .oclk     (out_clk)
    );

    generate
        if (STAG_D > 0) begin : g_stag
            ppf_stagger #(.W(PIX_W), .DEPTH(STAG_D)) u_stag (
                .clk (clk),
                .rst (rst),
                .d   (even_q),
                .q   (even_late)
            );
        end else begin : g_nostag
            assign even_late = even_q;
        end
    endgenerate

    assign stag_on  = cfg_dual && !cfg_stag_n;
    assign out_even = stag_on ? even_late : even_q;
    assign out_odd  = odd_q;
    assign out_de   = sync_q.de;
    assign out_hs   = sync_q.hs;
    assign out_vs   = sync_q.vs;
    assign out_ctl  = sync_q.ctl;

endmodule

// File: rtl/ppf_chk.sv
module ppf_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_dual,
    input logic        cfg_gate,
    input logic        cfg_rise,
    input logic        cfg_stag_n,
    input logic [23:0] out_even,
    input logic [23:0] out_odd,
    input logic        out_de,
    input logic        out_hs,
    input logic        out_vs,
    input logic [2:0]  out_ctl,
    input logic        out_clk
);

    AST_ODD_ZERO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !cfg_dual |-> out_odd == '0); // R1

    AST_BLANK_ODD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_de |-> out_odd == '0); // R8

    AST_BLANK_EVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!out_de && !(cfg_dual && !cfg_stag_n)) |-> out_even == '0); // R8

    AST_GATED_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_gate && !out_de) |-> !out_clk); // R4

    AST_RISE_LOW_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (cfg_rise && !$stable({out_odd, out_de, out_hs, out_vs, out_ctl}))
        |-> !out_clk); // R5

    AST_FALL_HIGH_AFTER_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rise && !(cfg_gate && !out_de)
         && !$stable({out_odd, out_de, out_hs, out_vs, out_ctl}))
        |-> out_clk); // R5

    AST_STAG_EVEN_LATE: assert property (@(posedge clk) disable iff (rst)
        (cfg_dual && !cfg_stag_n && !$stable(out_odd)) |-> $stable(out_even)); // R6

endmodule

bind pix_pair_fmt ppf_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_dual   (cfg_dual),
    .cfg_gate   (cfg_gate),
    .cfg_rise   (cfg_rise),
    .cfg_stag_n (cfg_stag_n),
    .out_even   (out_even),
    .out_odd    (out_odd),
    .out_de     (out_de),
    .out_hs     (out_hs),
    .out_vs     (out_vs),
    .out_ctl    (out_ctl),
    .out_clk    (out_clk)
);

// File: tb/test_pix_pair_fmt.sv
`timescale 1ns/1ps
module test_pix_pair_fmt;

    localparam int TICKS = 4;
    localparam int QD    = TICKS / 2;
    localparam int MAXC  = 2 * TICKS - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_stb = 1'b0;
    logic        pix_de = 1'b0, pix_hs = 1'b0, pix_vs = 1'b0;
    logic [2:0]  pix_ctl = '0;
    logic [23:0] pix_rgb = '0;
    logic        cfg_dual = 1'b0, cfg_gate = 1'b0, cfg_rise = 1'b0, cfg_stag_n = 1'b1;
    logic [23:0] out_even, out_odd;
    logic        out_de, out_hs, out_vs, out_clk;
    logic [2:0]  out_ctl;

    always #2 clk = ~clk;   // 250 MHz

    pix_pair_fmt #(.TICKS(TICKS)) i_pix_pair_fmt (
        .clk(clk), .rst(rst), .pix_stb(pix_stb), .pix_de(pix_de),
        .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_ctl(pix_ctl), .pix_rgb(pix_rgb),
        .cfg_dual(cfg_dual), .cfg_gate(cfg_gate), .cfg_rise(cfg_rise),
        .cfg_stag_n(cfg_stag_n), .out_even(out_even), .out_odd(out_odd),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_ctl(out_ctl),
        .out_clk(out_clk)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [23:0] e_even, e_odd, e_prev, pend_rgb;
    logic [5:0]  e_sync, pend_sync;
    bit          pend_v, emitted;
    int          cnt;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (dual=%0d gate=%0d rise=%0d stag_n=%0d)",
                     tag, what, act, exp, cfg_dual, cfg_gate, cfg_rise, cfg_stag_n);
        end
    endtask

    task automatic model_strobe();
        logic [5:0]  cs;
        logic [23:0] cr;
        cs = {pix_de, pix_hs, pix_vs, pix_ctl};
        cr = pix_de ? pix_rgb : 24'h0;
        if (!cfg_dual) begin
            e_prev = e_even; e_even = cr; e_odd = '0; e_sync = cs; emitted = 1;
        end else if (!pend_v) begin
            pend_v = 1; pend_rgb = pix_rgb; pend_sync = cs;
        end else begin
            e_prev  = e_even;
            e_even  = pend_sync[5] ? pend_rgb : 24'h0;
            e_sync  = pend_sync;
            emitted = 1;
            if (cs[5] == pend_sync[5]) begin
                e_odd  = cr;
                pend_v = 0;
            end else begin
                e_odd     = '0;
                pend_rgb  = pix_rgb;
                pend_sync = cs;
            end
        end
    endtask

    task automatic check_all();
        bit          stag, hi, gated, ec;
        int          half;
        logic [23:0] ev;
        string       te, to;
        stag  = cfg_dual && !cfg_stag_n;
        ev    = (stag && cnt < QD) ? e_prev : e_even;
        te    = (!e_sync[5] && !stag) ? "R8" : (stag ? "R6" : (cfg_dual ? "R2" : "R1"));
        to    = !e_sync[5] ? "R8" : (cfg_dual ? "R2" : "R1");
        chk(out_even == ev, te, "even bus", out_even, ev);
        chk(out_odd == e_odd, to, "odd bus", out_odd, e_odd);
        chk({out_de, out_hs, out_vs, out_ctl} == e_sync, "R9", "controls",
            {out_de, out_hs, out_vs, out_ctl}, e_sync);
        half  = cfg_dual ? TICKS : QD;
        hi    = (cnt >= half);
        gated = cfg_gate && !e_sync[5];
        ec    = gated ? 1'b0 : (cfg_rise ? hi : !hi);
        chk(out_clk == ec, gated ? "R4" : "R3,R5", "out_clk", out_clk, ec);
        if (!cfg_dual && cnt == 0 && e_sync[5]) begin
            chk(out_even[23:16] == e_even[23:16], "R7", "red field", out_even[23:16], e_even[23:16]);
            chk(out_even[15:8] == e_even[15:8], "R7", "green field", out_even[15:8], e_even[15:8]);
            chk(out_even[7:0] == e_even[7:0], "R7", "blue field", out_even[7:0], e_even[7:0]);
        end
    endtask

    task automatic cyc(bit s);
        @(posedge clk);
        emitted = 0;
        if (s) model_strobe();
        if (emitted) cnt = 0;
        else if (cnt < MAXC) cnt++;
        @(negedge clk);
        pix_stb = 1'b0;
        check_all();
    endtask

    task automatic pix(bit de, bit hs, bit vs, logic [2:0] ctl, logic [23:0] rgb);
        pix_de = de; pix_hs = hs; pix_vs = vs; pix_ctl = ctl; pix_rgb = rgb;
        pix_stb = 1'b1;
        cyc(1);
        for (int t = 1; t < TICKS; t++) cyc(0);
    endtask

    task automatic blank(int n, bit vs);
        for (int j = 0; j < n; j++) pix(1'b0, 1'b1, vs, 3'(j), 24'hA5C35A);
    endtask

    task automatic line(int li, int len);
        for (int k = 0; k < len; k++)
            pix(1'b1, 1'b0, 1'b0, 3'(li),
                {8'(li * 16 + k), 8'(k * 3 + 1), 8'(8'hF0 ^ k)});
    endtask

    task automatic run_combo(bit d, bit g, bit r, bit sn);
        int lens [6] = '{5, 4, 1, 6, 3, 2};
        int blks [6] = '{3, 2, 5, 1, 4, 2};
        @(negedge clk);
        rst = 1'b1;
        cfg_dual = d; cfg_gate = g; cfg_rise = r; cfg_stag_n = sn;
        pix_de = 1'b1; pix_hs = 1'b1; pix_vs = 1'b1; pix_ctl = 3'h7; pix_rgb = 24'hFFFFFF;
        pix_stb = 1'b1;
        repeat (3) @(negedge clk);
        pix_stb = 1'b0;
        // R10: reset state
        chk(out_even == 0 && out_odd == 0, "R10", "buses in reset", {out_even[15:0], out_odd[15:0]}, 0);
        chk({out_de, out_hs, out_vs, out_ctl} == 0, "R10", "controls in reset",
            {out_de, out_hs, out_vs, out_ctl}, 0);
        rst = 1'b0;
        e_even = '0; e_odd = '0; e_prev = '0; e_sync = '0;
        pend_v = 0; pend_rgb = '0; pend_sync = '0; cnt = 0;
        blank(3, 1'b0);
        for (int i = 0; i < 6; i++) begin
            line(i, lens[i]);
            blank(blks[i], i == 2);
        end
    endtask

    initial begin
        for (int c = 0; c < 16; c++)
            run_combo(c[0], c[1], c[2], c[3]);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule